// File: doc/BRIEF.md
# Monitor Conversion Scheduler

This block decides when a single shared 12-bit converter samples the supply voltage and when it samples the sense-amplifier current. A command byte written from the serial bus sets per-channel continuous and single-shot request bits plus a voltage range choice. The scheduler turns those bits into a start pulse and a channel select for the converter, waits for its done pulse, and stores the returned code in a per-channel holding register. A valid flag marks each holding register once it holds a real result. While a single-shot request is still pending it raises a busy flag, and the bus side uses that flag to refuse reads.

The controller is an FSM with three named states. `S_IDLE` waits for any request. The transition *grant* (some request present) latches the chosen channel, the range bit and whether the grant serves a single-shot request, then moves to `S_ISSUE`. `S_ISSUE` drives the start pulse for one cycle and always moves on by the transition *launch* to `S_WAIT`. `S_WAIT` holds the select until the done pulse arrives. The transition *land* then stores the code, clears the served single-shot bit and returns to `S_IDLE`. When both channels are requested, grants alternate between them.

Top module: `mon_conv_sched`

## Requirements
- R1: A write with `cmd_byte[7]`=0 loads the request bits: bit 0 continuous voltage, bit 1 single voltage, bit 2 continuous current, bit 3 single current, bit 4 range. A write with bit 7 set changes nothing. All bits reset to 0.
- R2: Every conversion is one `adc_start` pulse lasting one cycle. `adc_sel` (0 voltage, 1 current) stays fixed from that pulse until `adc_done`. No second start is issued before the done pulse.
- R3: When both channels are requested at grant time, the channel not served last is chosen. After reset, voltage goes first.
- R4: A single-shot bit clears at the done pulse of a conversion granted while that bit was set. A command write in the same cycle takes precedence.
- R5: `busy` is high exactly while either single-shot bit is set.
- R6: Holding registers and valid flags reset to 0, so a read before the first result returns zeros. Each done pulse replaces only the selected channel's register and sets its flag. Registers otherwise keep their value.
- R7: During a voltage conversion `adc_range` equals bit 4 as it was at grant. During a current conversion it is 0.
- R8: `curr_ready` pulses for one cycle, in the cycle after a current result lands, and at no other time.
- R9: Dropping a continuous bit during a conversion lets that conversion finish and keeps its result. No further start follows.
- R10: No start is issued when no request bit was set at grant time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Command byte |
| adc_done | input | 1 | Converter result available |
| adc_code | input | 12 | Converter result |
| adc_start | output | 1 | Start pulse to converter |
| adc_sel | output | 1 | Channel select, 0 voltage, 1 current |
| adc_range | output | 1 | Voltage range select |
| volt_code | output | 12 | Latest voltage result |
| curr_code | output | 12 | Latest current result |
| volt_valid | output | 1 | Voltage result present |
| curr_valid | output | 1 | Current result present |
| busy | output | 1 | Single-shot request pending |
| curr_ready | output | 1 | New current result strobe |

## Verification
The bench aims at four failure modes:
- **Arbitration fairness.** A design with fixed priority would starve current whenever voltage runs continuously.
- **Range capture timing.** A design that forwards the live range bit instead of the granted one would change `adc_range` in the middle of a conversion.
- **Single-shot clearing.** A design that clears the bit at start would drop `busy` too early. A design that clears on the wrong done pulse would keep reads refused.
- **Mid-conversion cancel.** A design that aborts on a continuous-bit cancel would lose the in-flight result.

Random command bytes, some with bit 7 set, run against a converter model with random latency. A reference model of the request bits predicts every output.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;
    typedef enum logic {CH_V = 1'b0, CH_I = 1'b1} chan_e;
    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_e;
    localparam int CMD_W = 8;
endpackage

// File: rtl/cs_cmd_reg.sv
module cs_cmd_reg
    import conv_sched_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CMD_W-1:0] wbyte,
    input  logic             clr_once_v,
    input  logic             clr_once_i,
    output logic             cont_v,
    output logic             once_v,
    output logic             cont_i,
    output logic             once_i,
    output logic             range
);
    logic load;
    assign load = wr && !wbyte[CMD_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cont_v <= 1'b0; once_v <= 1'b0; cont_i <= 1'b0;
            once_i <= 1'b0; range <= 1'b0;
        end else if (load) begin
            cont_v <= wbyte[0]; once_v <= wbyte[1]; cont_i <= wbyte[2];
            once_i <= wbyte[3]; range  <= wbyte[4];
        end else begin
            if (clr_once_v) once_v <= 1'b0;
            if (clr_once_i) once_i <= 1'b0;
        end
    end

    // R1: a byte flagged as extended leaves every request bit alone
    a_r1_ext_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wbyte[CMD_W-1] && !clr_once_v && !clr_once_i)
        |=> ($stable(cont_v) && $stable(cont_i) && $stable(once_v)
             && $stable(once_i) && $stable(range)));
endmodule

// File: rtl/cs_arbiter.sv
module cs_arbiter
    import conv_sched_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  req_v,
    input  logic  req_i,
    input  logic  take,
    output logic  any,
    output chan_e pick
);
    chan_e last_q;

    assign any = req_v || req_i;

    always_comb begin
        if (req_v && req_i) pick = (last_q == CH_V) ? CH_I : CH_V;
        else if (req_i)     pick = CH_I;
        else                pick = CH_V;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    last_q <= CH_I;
        else if (take) last_q <= pick;
    end

    // R3: with both requested, two consecutive grants never pick the same channel
    a_r3_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_v && req_i) |-> (pick != last_q));
endmodule

// File: rtl/cs_result_bank.sv
module cs_result_bank
    import conv_sched_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              land,
    input  chan_e             ch,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] v_code,
    output logic [CODE_W-1:0] i_code,
    output logic              v_valid,
    output logic              i_valid
);
    localparam int NCH = 2;
    logic [CODE_W-1:0] hold  [NCH];
    logic [NCH-1:0]    valid;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold[g]  <= '0;
                valid[g] <= 1'b0;
            end else if (land && (int'(ch) == g)) begin
                hold[g]  <= code;
                valid[g] <= 1'b1;
            end
        end
    end

    assign v_code  = hold[0];
    assign i_code  = hold[1];
    assign v_valid = valid[0];
    assign i_valid = valid[1];

    // R6: a holding register only moves when a result lands
    a_r6_hold_v: assert property (@(posedge clk) disable iff (!rst_n)
        !land |=> $stable(v_code));
    a_r6_hold_i: assert property (@(posedge clk) disable iff (!rst_n)
        !land |=> $stable(i_code));
    a_r6_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        v_valid |=> v_valid);
endmodule

// File: rtl/mon_conv_sched.sv
module mon_conv_sched
    import conv_sched_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [7:0]        cmd_byte,
    input  logic              adc_done,
    input  logic [CODE_W-1:0] adc_code,
    output logic              adc_start,
    output logic              adc_sel,
    output logic              adc_range,
    output logic [CODE_W-1:0] volt_code,
    output logic [CODE_W-1:0] curr_code,
    output logic              volt_valid,
    output logic              curr_valid,
    output logic              busy,
    output logic              curr_ready
);
    state_e state_q, state_d;
    chan_e  sel_q, pick;
    logic   range_q, once_q, any, grant, land;
    logic   cont_v, once_v, cont_i, once_i, range;

    cs_cmd_reg u_cmd (
        .clk(clk), .rst_n(rst_n), .wr(cmd_we), .wbyte(cmd_byte),
        .clr_once_v(land && once_q && sel_q == CH_V),
        .clr_once_i(land && once_q && sel_q == CH_I),
        .cont_v(cont_v), .once_v(once_v), .cont_i(cont_i),
        .once_i(once_i), .range(range));

    cs_arbiter u_arb (
        .clk(clk), .rst_n(rst_n), .req_v(cont_v || once_v),
        .req_i(cont_i || once_i), .take(grant), .any(any), .pick(pick));

    cs_result_bank #(.CODE_W(CODE_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .land(land), .ch(sel_q), .code(adc_code),
        .v_code(volt_code), .i_code(curr_code),
        .v_valid(volt_valid), .i_valid(curr_valid));

    assign grant = (state_q == S_IDLE) && any;
    assign land  = (state_q == S_WAIT) && adc_done;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            sel_q   <= CH_V;
            range_q <= 1'b0;
            once_q  <= 1'b0;
            curr_ready <= 1'b0;
        end else begin
            state_q <= state_d;
            curr_ready <= land && (sel_q == CH_I);
            if (grant) begin
                sel_q   <= pick;
                range_q <= range;
                once_q  <= (pick == CH_V) ? once_v : once_i;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        adc_start = 1'b0;
        unique case (state_q)
            S_IDLE:  if (any) state_d = S_ISSUE;
            S_ISSUE: begin
                adc_start = 1'b1;
                state_d   = S_WAIT;
            end
            S_WAIT:  if (adc_done) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    assign adc_sel   = (sel_q == CH_I);
    assign adc_range = (sel_q == CH_V) && (state_q != S_IDLE) ? range_q : 1'b0;
    assign busy      = once_v || once_i;

    // R2: start is a single-cycle pulse and select holds until done
    a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);
    a_r2_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && !adc_done) |=> $stable(adc_sel));
    // R8: ready strobe never lasts two cycles
    a_r8_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        curr_ready |=> !curr_ready);
    // R5: busy only falls after a done pulse or a command write
    a_r5_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !adc_done && !cmd_we) |=> busy);
    // R10: no launch without a pending request
    a_r10_no_idle_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !any) |=> !adc_start);
endmodule

// File: tb/mon_conv_sched_test.sv
module mon_conv_sched_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_we = 1'b0;
    logic [7:0] cmd_byte = '0;
    logic adc_done = 1'b0;
    logic [11:0] adc_code = '0;
    logic adc_start, adc_sel, adc_range, volt_valid, curr_valid, busy, curr_ready;
    logic [11:0] volt_code, curr_code;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    mon_conv_sched uut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference model, sampled at the same edge as the design
    logic m_cv, m_ov, m_ci, m_oi, m_rg, m_last;
    logic [1:0] req_prev, once_prev;
    logic range_prev;
    logic [11:0] e_v, e_i;
    logic e_vv, e_iv, e_strobe;
    logic s_ch, s_once, inflight;
    int lat;

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_cv, m_ov, m_ci, m_oi, m_rg} <= '0;
            req_prev <= '0; once_prev <= '0; range_prev <= 1'b0;
            e_v <= '0; e_i <= '0; e_vv <= 1'b0; e_iv <= 1'b0; e_strobe <= 1'b0;
        end else begin
            req_prev   <= {m_ci | m_oi, m_cv | m_ov};
            once_prev  <= {m_oi, m_ov};
            range_prev <= m_rg;
            if (cmd_we && !cmd_byte[7])
                {m_rg, m_oi, m_ci, m_ov, m_cv} <= cmd_byte[4:0];
            else if (adc_done && s_once) begin
                if (s_ch) m_oi <= 1'b0; else m_ov <= 1'b0;
            end
            e_strobe <= adc_done && s_ch;
            if (adc_done) begin
                if (s_ch) begin e_i <= adc_code; e_iv <= 1'b1; end
                else      begin e_v <= adc_code; e_vv <= 1'b1; end
            end
        end
    end

    // converter model and per-cycle checks
    always @(negedge clk) begin
        adc_done = 1'b0;
        if (!rst_n) begin
            inflight = 0; lat = 0; m_last = 1'b1; s_ch = 0; s_once = 0;
        end else if (!finished) begin
            chk(busy == (m_ov | m_oi), "R5 busy", busy, m_ov | m_oi);
            chk(volt_code == e_v && volt_valid == e_vv, "R6 voltage hold", volt_code, e_v);
            chk(curr_code == e_i && curr_valid == e_iv, "R6 current hold", curr_code, e_i);
            chk(curr_ready == e_strobe, "R8 ready strobe", curr_ready, e_strobe);
            if (inflight) begin
                chk(!adc_start, "R2 start during conversion", adc_start, 0);
                chk(adc_sel == s_ch, "R2 select held", adc_sel, s_ch);
                lat--;
                if (lat == 0) begin
                    adc_done = 1'b1;
                    adc_code = 12'($urandom);
                    inflight = 0;
                end
            end else if (adc_start) begin
                logic exp_ch;
                chk(req_prev != 2'b00, "R10 start without request", adc_start, 0);
                exp_ch = (req_prev == 2'b11) ? ~m_last : req_prev[1];
                chk(adc_sel == exp_ch, "R3 channel choice", adc_sel, exp_ch);
                chk(adc_range == (exp_ch ? 1'b0 : range_prev), "R7 range",
                    adc_range, exp_ch ? 0 : range_prev);
                m_last = adc_sel;
                s_ch = adc_sel;
                s_once = adc_sel ? once_prev[1] : once_prev[0];
                inflight = 1;
                lat = 1 + int'($urandom % 6);
            end
        end
    end

    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        cmd_we = 1'b1; cmd_byte = b;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd1234));
        idle(3);
        // R6 / R1: reset state
        chk(volt_code == 0 && curr_code == 0, "R6 reset zeros", volt_code, 0);
        chk(!volt_valid && !curr_valid && !busy && !adc_start, "R1 reset bits", busy, 0);
        rst_n = 1'b1;
        idle(5);
        chk(!adc_start, "R10 quiet after reset", adc_start, 0);
        // R6: continuous read before result returns zeros
        wr(8'h01);
        chk(volt_code == 0 && !volt_valid, "R6 zeros before first result", volt_code, 0);
        idle(30);
        chk(volt_valid, "R6 voltage valid after run", volt_valid, 1);
        // R9: drop continuous bit, result still lands, then nothing
        @(posedge adc_start);
        wr(8'h00);
        idle(12);
        begin
            int starts = 0;
            repeat (20) begin @(negedge clk); if (adc_start) starts++; end
            chk(starts == 0, "R9 no start after cancel", starts, 0);
        end
        // R4: single shot current with range set
        wr(8'h18);
        chk(busy, "R4 busy while single pending", busy, 1);
        idle(20);
        chk(!busy && curr_valid, "R4 single bit cleared", busy, 0);
        // R1: extended byte ignored
        wr(8'h83);
        idle(10);
        chk(!busy, "R1 extended write ignored", busy, 0);
        // R3 / R7: both continuous, range narrow
        wr(8'h15);
        idle(80);
        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [7:0] b = 8'($urandom);
            if (($urandom % 4) != 0) b[7] = 1'b0;
            wr(b);
            idle(int'($urandom % 30));
        end
        wr(8'h00);
        idle(20);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        finished = 1;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule